// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the device-side engine of a parallel programming port for a 1024-byte code flash. An external programmer does not present an address. It opens a session, which clears an internal 10-bit address counter, and then steps that counter with increment pulses. Static mode lines, qualified by a high-voltage flag, choose one of several operations. A low-going program strobe then starts it. The array is modelled in registers, so cell physics is replaced by cycle counts given as parameters.

A byte write is self-timed. Ready drops for a fixed number of clocks, and a programmed byte can only lose ones. While a write is in flight, a read returns the pending byte with bit 7 inverted, which lets the programmer poll for completion. Chip erase needs the strobe held low for a parameterised number of cycles. Two lock bits gate further programming and readback, and only an erase clears them. A signature mode returns fixed identification bytes at the first two addresses.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A rising edge of `sess_i` clears the address counter to 0. Each rising edge of `incr_i` adds one, and address 1023 wraps to 0.
- R2: A rising edge of `incr_i` that arrives while `ready_o` is low leaves the address unchanged.
- R3: After `rst_n` every byte reads FFH. In read mode (`sess_i`=1, `hv_i`=0, `mode_i`=4'b1100) `data_oe_o` is 1 and `data_o` is the byte at the current address.
- R4: In write mode (`sess_i`=1, `hv_i`=1, `mode_i`=4'b1110), a rising edge of `prog_n_i` starts a write while ready. `ready_o` is low for exactly WR_CYCLES clocks, starting after that edge. The stored byte becomes the old byte AND `data_i`.
- R5: While a byte write is pending, read mode returns the new byte with bit 7 inverted. Once ready returns, it returns the true byte.
- R6: In erase mode (`hv_i`=1, `mode_i`=4'b0001), holding `prog_n_i` low for ERASE_CYCLES consecutive clocks sets every byte to FFH and clears both lock bits. A shorter hold changes nothing.
- R7: Lock bit 1 is set by a strobe in mode 4'b1111 with `hv_i`=1, which takes WR_CYCLES clocks. While it is set, a write strobe starts nothing: ready stays high and the data stays as it was.
- R8: Lock bit 2 is set by a strobe in mode 4'b0011 with `hv_i`=1. With both lock bits set, read mode returns FFH, while signature mode still works.
- R9: In signature mode (`hv_i`=0, `mode_i`=4'b0000), address 0 returns 1EH, address 1 returns 11H, and any other address returns FFH.
- R10: With `sess_i` low, or with any other mode/flag combination, `data_oe_o` is 0 and a strobe starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; array returns to erased, locks clear |
| sess_i | input | 1 | Programming session enable; rising edge clears address |
| hv_i | input | 1 | High-voltage present flag |
| prog_n_i | input | 1 | Active-low program strobe |
| mode_i | input | 4 | Operation select lines |
| incr_i | input | 1 | Address increment pulse (rising edge) |
| data_i | input | 8 | Data from programmer |
| data_o | output | 8 | Data to programmer |
| data_oe_o | output | 1 | Data bus drive enable |
| ready_o | output | 1 | High when no self-timed write is running |

## Verification
Byte writes go to fresh, already-written and last addresses. Writing F0H over A5H shows whether the array ANDs the new byte in or simply overwrites. Polling reads taken mid-write and after completion separate the inverted-bit-7 view from the committed data. Erase holds one cycle short of the limit and exactly at it pin down the hold threshold. Lock sequences, signature reads past address 1 and illegal mode words each check that gated operations leave the ready line and the stored data untouched.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_READ,
    OP_LOCK1,
    OP_LOCK2,
    OP_ERASE,
    OP_SIG
  } op_e;

  localparam logic [3:0] MD_WRITE = 4'b1110;
  localparam logic [3:0] MD_READ  = 4'b1100;
  localparam logic [3:0] MD_LOCK1 = 4'b1111;
  localparam logic [3:0] MD_LOCK2 = 4'b0011;
  localparam logic [3:0] MD_ERASE = 4'b0001;
  localparam logic [3:0] MD_SIG   = 4'b0000;

  function automatic op_e decode_op(input logic sess, input logic hv,
                                    input logic [3:0] md);
    op_e r;
    r = OP_NONE;
    if (sess) begin
      if (hv) begin
        if (md == MD_WRITE)      r = OP_WRITE;
        else if (md == MD_LOCK1) r = OP_LOCK1;
        else if (md == MD_LOCK2) r = OP_LOCK2;
        else if (md == MD_ERASE) r = OP_ERASE;
      end else begin
        if (md == MD_READ)       r = OP_READ;
        else if (md == MD_SIG)   r = OP_SIG;
      end
    end
    return r;
  endfunction

  // programming can only pull bits to zero
  function automatic logic [7:0] merge_byte(input logic [7:0] old_b,
                                            input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  function automatic logic [7:0] poll_byte(input logic [7:0] b);
    return {~b[7], b[6:0]};
  endfunction

  function automatic logic [7:0] sig_byte(input logic [15:0] a);
    logic [7:0] r;
    case (a)
      16'd0:   r = 8'h1E;
      16'd1:   r = 8'h11;
      default: r = 8'hFF;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpc_addr_ctr.sv
module fpc_addr_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_i,
  input  logic              incr_i,
  input  logic              hold_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sess_rise_o,
  output logic              incr_rise_o
);

  logic sess_q, incr_q;

  assign sess_rise_o = sess_i & ~sess_q;
  assign incr_rise_o = incr_i & ~incr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q <= 1'b0;
      incr_q <= 1'b0;
      addr_o <= '0;
    end else begin
      sess_q <= sess_i;
      incr_q <= incr_i;
      if (sess_rise_o)
        addr_o <= '0;
      else if (incr_rise_o && !hold_i)
        addr_o <= addr_o + 1'b1;
    end
  end

  AST_ADDR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    sess_rise_o |=> (addr_o == '0)); // R1

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !sess_rise_o) |=> $stable(addr_o)); // R2

endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int WR_CYCLES    = 2400,
  parameter int ERASE_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  op_e  op_i,
  input  logic prog_n_i,
  input  logic wr_block_i,
  output logic start_o,
  output logic busy_o,
  output logic done_o,
  output logic erase_fire_o
);

  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam int EW = $clog2(ERASE_CYCLES + 1);

  logic          prog_q;
  logic          strobe_rise;
  logic [CW-1:0] cnt_q;
  logic [EW-1:0] ecnt_q;
  logic          efired_q;
  logic          erase_hold;
  logic          wants_write;

  assign strobe_rise  = prog_n_i & ~prog_q;
  assign wants_write  = ((op_i == OP_WRITE) && !wr_block_i) ||
                        (op_i == OP_LOCK1) || (op_i == OP_LOCK2);
  assign start_o      = strobe_rise && !busy_o && wants_write;
  assign done_o       = busy_o && (cnt_q == '0);
  assign erase_hold   = (op_i == OP_ERASE) && !prog_n_i && !busy_o;
  assign erase_fire_o = erase_hold && !efired_q &&
                        (ecnt_q == EW'(ERASE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b1;
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prog_q <= prog_n_i;
      if (start_o) begin
        busy_o <= 1'b1;
        cnt_q  <= CW'(WR_CYCLES - 1);
      end else if (done_o) begin
        busy_o <= 1'b0;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q   <= '0;
      efired_q <= 1'b0;
    end else if (!erase_hold) begin
      ecnt_q   <= '0;
      efired_q <= 1'b0;
    end else if (erase_fire_o) begin
      efired_q <= 1'b1;
    end else if (!efired_q) begin
      ecnt_q <= ecnt_q + 1'b1;
    end
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o); // R4

  AST_ERASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire_o |-> (!prog_n_i && !prog_q)); // R6

endmodule

// File: rtl/fpc_array.sv
module fpc_array
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  op_e               op_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              erase_i,
  output logic [7:0]        rd_byte_o,
  output logic [7:0]        poll_o,
  output logic              lock1_o,
  output logic              lock2_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        mem [DEPTH];
  logic [7:0]        wbyte_q;
  logic [ADDR_W-1:0] waddr_q;
  op_e               wkind_q;

  assign rd_byte_o = mem[addr_i];
  assign poll_o    = poll_byte(wbyte_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      lock1_o <= 1'b0;
      lock2_o <= 1'b0;
      wbyte_q <= 8'hFF;
      waddr_q <= '0;
      wkind_q <= OP_NONE;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      lock1_o <= 1'b0;
      lock2_o <= 1'b0;
    end else begin
      if (start_i) begin
        waddr_q <= addr_i;
        wbyte_q <= merge_byte(mem[addr_i], data_i);
        wkind_q <= op_i;
      end
      if (done_i) begin
        case (wkind_q)
          OP_WRITE: mem[waddr_q] <= wbyte_q;
          OP_LOCK1: lock1_o <= 1'b1;
          OP_LOCK2: lock2_o <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock1_o && !erase_i) |=> lock1_o); // R7

  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (!lock1_o && !lock2_o && mem[0] == 8'hFF)); // R6

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int WR_CYCLES    = 2400,
  parameter int ERASE_CYCLES = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sess_i,
  input  logic       hv_i,
  input  logic       prog_n_i,
  input  logic [3:0] mode_i,
  input  logic       incr_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic       ready_o
);

  op_e               op;
  logic [ADDR_W-1:0] addr;
  logic              sess_rise, incr_rise;
  logic              start, busy, done, erase_fire;
  logic [7:0]        rd_byte, poll;
  logic              lock1, lock2;

  assign op      = decode_op(sess_i, hv_i, mode_i);
  assign ready_o = ~busy;

  fpc_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .sess_i(sess_i), .incr_i(incr_i),
    .hold_i(busy), .addr_o(addr), .sess_rise_o(sess_rise),
    .incr_rise_o(incr_rise)
  );

  fpc_seq #(.WR_CYCLES(WR_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .op_i(op), .prog_n_i(prog_n_i),
    .wr_block_i(lock1), .start_o(start), .busy_o(busy), .done_o(done),
    .erase_fire_o(erase_fire)
  );

  fpc_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .data_i(data_i), .op_i(op),
    .start_i(start), .done_i(done), .erase_i(erase_fire),
    .rd_byte_o(rd_byte), .poll_o(poll), .lock1_o(lock1), .lock2_o(lock2)
  );

  always_comb begin
    data_oe_o = 1'b0;
    data_o    = 8'h00;
    case (op)
      OP_READ: begin
        data_oe_o = 1'b1;
        if (busy)               data_o = poll;
        else if (lock1 && lock2) data_o = 8'hFF;
        else                    data_o = rd_byte;
      end
      OP_SIG: begin
        data_oe_o = 1'b1;
        data_o    = sig_byte(16'(addr));
      end
      default: ;
    endcase
  end

  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sess_i) |-> !data_oe_o); // R10

  AST_NO_START_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE && ready_o) |=> ready_o); // R10

  AST_INCR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (incr_rise && busy && !sess_rise) |=> (addr == $past(addr))); // R2

endmodule

// File: tb/flash_prog_ctrl_test.sv
`timescale 1ns/1ps
module flash_prog_ctrl_test;

  localparam int WR = 6;
  localparam int ER = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sess = 1'b0, hv = 1'b0, prog_n = 1'b1, incr = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       doe, ready;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(10), .WR_CYCLES(WR), .ERASE_CYCLES(ER)) uut (
    .clk(clk), .rst_n(rst_n), .sess_i(sess), .hv_i(hv), .prog_n_i(prog_n),
    .mode_i(mode), .incr_i(incr), .data_i(din), .data_o(dout),
    .data_oe_o(doe), .ready_o(ready)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic set_md(input logic h, input logic [3:0] m);
    @(negedge clk);
    hv = h; mode = m;
  endtask

  task automatic new_session();
    @(negedge clk) sess = 1'b0;
    @(negedge clk) sess = 1'b1;
    @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk) incr = 1'b1;
    @(negedge clk) incr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] m, output logic [7:0] v);
    set_md(1'b0, m);
    @(negedge clk);
    v = dout;
  endtask

  task automatic strobe_count(output int n);
    @(negedge clk) prog_n = 1'b0;
    @(negedge clk) prog_n = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ready) break;
      n++;
    end
  endtask

  task automatic wr_byte(input logic [7:0] d, output int n);
    set_md(1'b1, 4'b1110);
    din = d;
    strobe_count(n);
  endtask

  task automatic erase_hold(input int cyc);
    set_md(1'b1, 4'b0001);
    @(negedge clk) prog_n = 1'b0;
    repeat (cyc) @(negedge clk);
    prog_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R10 ready after reset", ready, 1);
    chk("R10 no drive without session", doe, 0);
    new_session();
    rd(4'b1100, v);
    chk("R3 read enable", doe, 1);
    chk("R3 erased byte", v, 8'hFF);
  endtask

  task automatic t_write_addr();
    logic [7:0] v; int n;
    wr_byte(8'hA5, n);
    chk("R4 busy length", n, WR);
    rd(4'b1100, v);
    chk("R4 byte at 0", v, 8'hA5);
    step();
    wr_byte(8'h3C, n);
    new_session();
    rd(4'b1100, v);
    chk("R1 address cleared", v, 8'hA5);
    step();
    rd(4'b1100, v);
    chk("R1 increment", v, 8'h3C);
    new_session();
    wr_byte(8'hF0, n);
    rd(4'b1100, v);
    chk("R4 AND merge", v, 8'hA0);
  endtask

  task automatic t_erase_short();
    logic [7:0] v;
    erase_hold(ER - 1);
    rd(4'b1100, v);
    chk("R6 short hold no erase", v, 8'hA0);
  endtask

  task automatic t_poll();
    logic [7:0] v;
    step(); step();
    set_md(1'b1, 4'b1110);
    din = 8'h81;
    @(negedge clk) prog_n = 1'b0;
    @(negedge clk) prog_n = 1'b1;
    @(negedge clk) begin hv = 1'b0; mode = 4'b1100; end
    @(negedge clk);
    chk("R5 busy seen", ready, 0);
    chk("R5 polled byte", dout, 8'h01);
    for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
    @(negedge clk);
    chk("R5 true byte", dout, 8'h81);
  endtask

  task automatic t_busy_incr();
    logic [7:0] v;
    step();
    set_md(1'b1, 4'b1110);
    din = 8'h7E;
    @(negedge clk) prog_n = 1'b0;
    @(negedge clk) prog_n = 1'b1;
    @(negedge clk) incr = 1'b1;
    @(negedge clk) incr = 1'b0;
    chk("R2 still busy at step", ready, 0);
    for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
    rd(4'b1100, v);
    chk("R2 address held", v, 8'h7E);
    step();
    rd(4'b1100, v);
    chk("R2 next address", v, 8'hFF);
  endtask

  task automatic t_wrap();
    logic [7:0] v; int n;
    new_session();
    for (int i = 0; i < 1023; i++) step();
    rd(4'b1100, v);
    chk("R1 last address blank", v, 8'hFF);
    wr_byte(8'h55, n);
    rd(4'b1100, v);
    chk("R1 last address written", v, 8'h55);
    step();
    rd(4'b1100, v);
    chk("R1 wrap to 0", v, 8'hA0);
  endtask

  task automatic t_sig();
    logic [7:0] v;
    new_session();
    rd(4'b0000, v);
    chk("R9 sig 0", v, 8'h1E);
    step();
    rd(4'b0000, v);
    chk("R9 sig 1", v, 8'h11);
    step();
    rd(4'b0000, v);
    chk("R9 sig 2", v, 8'hFF);
  endtask

  task automatic t_none();
    logic [7:0] v; int n;
    set_md(1'b1, 4'b1010);
    @(negedge clk);
    chk("R10 bad mode no drive", doe, 0);
    strobe_count(n);
    chk("R10 bad mode no busy", n, 0);
    @(negedge clk) sess = 1'b0;
    wr_byte(8'h00, n);
    chk("R10 no session no busy", n, 0);
    chk("R10 no session no drive", doe, 0);
    new_session();
    rd(4'b1100, v);
    chk("R10 data untouched", v, 8'hA0);
  endtask

  task automatic t_lock();
    logic [7:0] v; int n;
    set_md(1'b1, 4'b1111);
    strobe_count(n);
    chk("R7 lock1 write time", n, WR);
    new_session();
    wr_byte(8'h00, n);
    chk("R7 write blocked", n, 0);
    rd(4'b1100, v);
    chk("R7 data kept", v, 8'hA0);
    set_md(1'b1, 4'b0011);
    strobe_count(n);
    chk("R8 lock2 write time", n, WR);
    rd(4'b1100, v);
    chk("R8 verify hidden", v, 8'hFF);
    rd(4'b0000, v);
    chk("R8 sig still readable", v, 8'h1E);
  endtask

  task automatic t_erase_full();
    logic [7:0] v; int n;
    erase_hold(ER);
    new_session();
    rd(4'b1100, v);
    chk("R6 erased byte 0", v, 8'hFF);
    step();
    rd(4'b1100, v);
    chk("R6 erased byte 1", v, 8'hFF);
    new_session();
    wr_byte(8'h12, n);
    chk("R6 locks cleared, write runs", n, WR);
    rd(4'b1100, v);
    chk("R6 write after erase", v, 8'h12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_addr();
    t_erase_short();
    t_poll();
    t_busy_incr();
    t_wrap();
    t_sig();
    t_none();
    t_lock();
    t_erase_full();
    summary();
  end

endmodule